// File: doc/BRIEF.md
# Periodic Wakeup Down-Counter with Cross-Domain Enable Handshake

The block produces a periodic wakeup event in a slow timekeeping clock domain. It is configured from a faster bus clock domain. In the slow domain a 16-bit down-counter steps once per tick of a selected source. Eight pre-generated tick enables are offered, and a 3-bit select picks one. When the counter hits zero it reloads and raises a one-cycle wakeup pulse. The same pulse is also carried back to the bus side, where it sets a sticky flag that software clears by writing a 1.

The bus side owns four write locations: a control word with the enable bit, the 16-bit reload value, the 3-bit source select, and the status word. Changing the reload or select while the slow side is counting would be unsafe. For that reason these two fields are guarded by a read-only write-allowed flag. The flag rises only after the slow side has confirmed, through a two-flop synchronizer in each direction, that counting has stopped. Software therefore clears the enable, waits for the flag, rewrites the fields, and then sets the enable again. Counting then restarts from the new reload value.

Top module: `wkup_timer`

## Requirements
- R1: After reset, `en_o` is 0, `wr_ok_o` is 1, `reload_o` is 0xFFFF, `sel_o` is 0, `wake_flag_o` is 0 and `wake_o` is 0.
- R2: A write with `wr_addr_i`=0 sets the enable from data bit 0. `wr_addr_i`=1 writes the reload value from data bits 15:0. `wr_addr_i`=2 writes the source select from data bits 2:0. `wr_addr_i`=3 is the status word.
- R3: `wr_ok_o` falls in the bus cycle after the enable is set. It stays low while the slow side counts, and it rises within three slow cycles after the enable is cleared. A write to the enable is ignored while its previous change has not yet come back from the slow domain.
- R4: Writes to the reload value or the select while `wr_ok_o` is 0 are ignored.
- R5: While the slow side sees the enable low, the counter holds the reload value and `wake_o` stays 0.
- R6: While counting, `wake_o` pulses for one slow cycle every reload+1 selected ticks, including reload 0, which pulses on every tick. Each re-enable restarts the count from the reload value.
- R7: Each wakeup sets `wake_flag_o` three bus cycles after the pulse. Writing status bit 0 as 1 clears it, writing it as 0 leaves it set, and a set in the same cycle as a clear wins.
- R8: Ticks on sources other than the one chosen by `sel_o` do not move the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Bus domain asynchronous reset, active low |
| rtc_clk_i | input | 1 | Slow timekeeping clock |
| rtc_rst_ni | input | 1 | Slow domain asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write location |
| wr_data_i | input | 16 | Write data |
| tick_i | input | 8 | Tick enables in the slow domain, one per source |
| en_o | output | 1 | Enable bit, bus domain |
| wr_ok_o | output | 1 | Reload and select may be written |
| reload_o | output | 16 | Reload value |
| sel_o | output | 3 | Tick source select |
| wake_flag_o | output | 1 | Sticky wakeup flag, bus domain |
| wake_o | output | 1 | One-cycle wakeup pulse, slow domain |

## Verification
The counter is run with ticks every cycle, on sparse sources with different periods, and with reload values of 3, 5 and 0. These runs separate a correct period from an off-by-one and show that the select really chooses the source. A run in which only non-selected sources tick shows that the mux is honoured. Reconfiguration is tried both while counting and after the flag returns, which separates a guarded write from one that leaks through. A set-then-immediate-clear of the enable checks that a change still in flight is ignored. Every bus and slow cycle is compared against a reference model built on per-domain sample queues, so latency errors in either synchronizer show up as cycle mismatches.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_SEL    = 2'd2,
    ADDR_STAT   = 2'd3
  } wkt_addr_e;
endpackage

// File: rtl/wkt_sync.sv
module wkt_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wkt_count.sv
module wkt_count #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3,
  localparam int NSRC = 1 << SEL_W
) (
  input  logic             rtc_clk_i,
  input  logic             rtc_rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NSRC-1:0]  tick_i,
  output logic             wake_o,
  output logic             tgl_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wake_q, tgl_q;
  logic             step;

  assign step = tick_i[sel_i];

  always_ff @(posedge rtc_clk_i or negedge rtc_rst_ni) begin
    if (!rtc_rst_ni) begin
      cnt_q  <= '1;
      wake_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      if (!run_i) begin
        cnt_q <= reload_i;  // idle: preload so re-enable starts fresh
      end else if (step) begin
        if (cnt_q == '0) begin
          cnt_q  <= reload_i;
          wake_q <= 1'b1;
          tgl_q  <= ~tgl_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign wake_o = wake_q;
  assign tgl_o  = tgl_q;
endmodule

// File: rtl/wkt_regs.sv
module wkt_regs
  import wkt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             run_b_i,
  input  logic             tgl_b_i,
  output logic             en_o,
  output logic             wr_ok_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             wake_flag_o
);
  wkt_addr_e        addr;
  logic             en_q, flag_q, tgl_q;
  logic [CNT_W-1:0] reload_q;
  logic [SEL_W-1:0] sel_q;
  logic             wake_evt, settled;

  assign addr     = wkt_addr_e'(wr_addr_i);
  assign settled  = (en_q == run_b_i);  // previous enable change has returned
  assign wr_ok_o  = !en_q && !run_b_i;
  assign wake_evt = tgl_b_i ^ tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      reload_q <= '1;
      sel_q    <= '0;
      flag_q   <= 1'b0;
      tgl_q    <= 1'b0;
    end else begin
      tgl_q <= tgl_b_i;
      if (wr_en_i && addr == ADDR_CTRL && settled) en_q <= wr_data_i[0];
      if (wr_en_i && addr == ADDR_RELOAD && wr_ok_o) reload_q <= wr_data_i;
      if (wr_en_i && addr == ADDR_SEL && wr_ok_o) sel_q <= wr_data_i[SEL_W-1:0];
      if (wake_evt) flag_q <= 1'b1;
      else if (wr_en_i && addr == ADDR_STAT && wr_data_i[0]) flag_q <= 1'b0;
    end
  end

  assign en_o        = en_q;
  assign reload_o    = reload_q;
  assign sel_o       = sel_q;
  assign wake_flag_o = flag_q;
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3,
  localparam int NSRC = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rtc_clk_i,
  input  logic             rtc_rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [NSRC-1:0]  tick_i,
  output logic             en_o,
  output logic             wr_ok_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             wake_flag_o,
  output logic             wake_o
);
  logic run_s, run_b, tgl_s, tgl_b;

  wkt_sync #(.W(1)) u_en_to_rtc (
    .clk_i (rtc_clk_i), .rst_ni(rtc_rst_ni), .d_i(en_o), .q_o(run_s)
  );

  wkt_sync #(.W(2)) u_rtc_to_bus (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i({run_s, tgl_s}), .q_o({run_b, tgl_b})
  );

  wkt_count #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_count (
    .rtc_clk_i (rtc_clk_i),
    .rtc_rst_ni(rtc_rst_ni),
    .run_i     (run_s),
    .reload_i  (reload_o),
    .sel_i     (sel_o),
    .tick_i    (tick_i),
    .wake_o    (wake_o),
    .tgl_o     (tgl_s)
  );

  wkt_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .run_b_i    (run_b),
    .tgl_b_i    (tgl_b),
    .en_o       (en_o),
    .wr_ok_o    (wr_ok_o),
    .reload_o   (reload_o),
    .sel_o      (sel_o),
    .wake_flag_o(wake_flag_o)
  );
endmodule

// File: rtl/wkt_chk.sv
module wkt_chk #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rtc_clk_i,
  input logic             rtc_rst_ni,
  input logic             run_s,
  input logic             wr_ok_o,
  input logic [CNT_W-1:0] reload_o,
  input logic [SEL_W-1:0] sel_o,
  input logic             wake_o
);
  assert_rtc_busy_blocks_R3: assert property (
    @(posedge rtc_clk_i) disable iff (!rtc_rst_ni) run_s |-> !wr_ok_o);

  assert_cfg_frozen_R4: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
      !wr_ok_o |=> ($stable(reload_o) && $stable(sel_o)));

  assert_no_wake_idle_R5: assert property (
    @(posedge rtc_clk_i) disable iff (!rtc_rst_ni) !run_s |=> !wake_o);

  assert_wake_single_R6: assert property (
    @(posedge rtc_clk_i) disable iff (!rtc_rst_ni)
      (wake_o && reload_o != '0) |=> !wake_o);
endmodule

bind wkup_timer wkt_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rtc_clk_i (rtc_clk_i),
  .rtc_rst_ni(rtc_rst_ni),
  .run_s     (run_s),
  .wr_ok_o   (wr_ok_o),
  .reload_o  (reload_o),
  .sel_o     (sel_o),
  .wake_o    (wake_o)
);

// File: tb/wkup_timer_bench.sv
module wkup_timer_bench;
  logic        clk = 1'b0, rtc = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  tick_r = '0, tick_mask = 8'hFF;
  logic        en_o, wr_ok_o, wake_flag_o, wake_o;
  logic [15:0] reload_o;
  logic [2:0]  sel_o;
  int total = 0, bad = 0, slow_cyc = 0;
  bit done = 0;

  wkup_timer u_wkup_timer (
    .clk_i(clk), .rst_ni(rst_n), .rtc_clk_i(rtc), .rtc_rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .tick_i(tick_r),
    .en_o(en_o), .wr_ok_o(wr_ok_o), .reload_o(reload_o), .sel_o(sel_o),
    .wake_flag_o(wake_flag_o), .wake_o(wake_o)
  );

  always #4 clk = ~clk;  // 125 MHz
  initial begin
    #8;
    forever begin rtc = 1'b1; #32; rtc = 1'b0; #32; end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // reference model: bus side
  logic        m_en, m_flag, m_run_b;
  logic [15:0] m_reload;
  logic [2:0]  m_sel;
  logic        rq[$];
  int          tq[$];
  // reference model: slow side
  logic        m_run, m_wake;
  logic [15:0] m_cnt;
  int          m_wcnt;
  logic        eq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_flag = 0; m_run_b = 0; m_reload = 16'hFFFF; m_sel = 0;
      rq = '{0, 0, 0, 0}; tq = '{0, 0, 0, 0};
    end else begin
      bit ok_prev, settled, set_evt;
      ok_prev = !m_en && !m_run_b;
      settled = (m_en == m_run_b);
      rq.push_back(m_run); void'(rq.pop_front());
      tq.push_back(m_wcnt); void'(tq.pop_front());
      m_run_b = rq[rq.size()-2];
      set_evt = tq[tq.size()-3] != tq[tq.size()-4];
      if (wr_en) begin
        case (wr_addr)
          2'd0: if (settled) m_en = wr_data[0];
          2'd1: if (ok_prev) m_reload = wr_data;
          2'd2: if (ok_prev) m_sel = wr_data[2:0];
          default: if (wr_data[0]) m_flag = 0;
        endcase
      end
      if (set_evt) m_flag = 1;
    end
  end

  always @(posedge rtc) begin
    if (!rst_n) begin
      m_run = 0; m_wake = 0; m_cnt = 16'hFFFF; m_wcnt = 0; eq = '{0, 0};
    end else begin
      m_wake = 0;
      if (!m_run) m_cnt = m_reload;
      else if (tick_r[m_sel]) begin
        if (m_cnt == 0) begin m_cnt = m_reload; m_wake = 1; m_wcnt++; end
        else m_cnt = m_cnt - 1;
      end
      eq.push_back(m_en); void'(eq.pop_front());
      m_run = eq[eq.size()-2];
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #6;
    if (rst_n && !done) begin
      chk("R2", "en_o", en_o, m_en);
      chk("R3", "wr_ok_o", wr_ok_o, !m_en && !m_run_b);
      chk("R4", "reload_o", reload_o, m_reload);
      chk("R4", "sel_o", sel_o, m_sel);
      chk("R7", "wake_flag_o", wake_flag_o, m_flag);
    end
  end

  always @(posedge rtc) begin
    #3;
    if (rst_n && !done) chk("R6", "wake_o", wake_o, m_wake);
  end

  // slow-domain tick sources: source i ticks every i+1 slow cycles
  always @(posedge rtc) begin
    #10;
    slow_cyc++;
    for (int i = 0; i < 8; i++) tick_r[i] = tick_mask[i] && (slow_cyc % (i + 1) == 0);
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(posedge rtc);
    #3;
  endtask

  task automatic count_wake(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge rtc); #3;
      if (wake_o) c++;
    end
  endtask

  task automatic wait_ok();
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); #6;
      if (wr_ok_o) break;
    end
  endtask

  initial begin
    int c;
    #102 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #6;
    chk("R1", "en after reset", en_o, 0);
    chk("R1", "wr_ok after reset", wr_ok_o, 1);
    chk("R1", "reload after reset", reload_o, 16'hFFFF);
    chk("R1", "sel after reset", sel_o, 0);
    chk("R1", "flag after reset", wake_flag_o, 0);
    chk("R1", "wake after reset", wake_o, 0);

    // reload 3 on source 0 (every cycle): period 4
    wr(2'd1, 16'd3); wr(2'd2, 16'd0); wr(2'd0, 16'd1);
    #4 chk("R3", "wr_ok drops after enable", wr_ok_o, 0);
    wait_slow(10);
    count_wake(40, c);
    chk("R6", "pulses reload 3 every tick", c, 10);

    // attempts while counting are ignored
    wr(2'd1, 16'd7); wr(2'd2, 16'd1);
    #4;
    chk("R4", "reload kept while busy", reload_o, 3);
    chk("R4", "sel kept while busy", sel_o, 0);

    wr(2'd0, 16'd0);
    wait_ok();
    chk("R3", "wr_ok returns after disable", wr_ok_o, 1);
    count_wake(20, c);
    chk("R5", "no pulses while disabled", c, 0);

    // reload 5 on source 5 (every 6 cycles): period 36 cycles
    wr(2'd1, 16'd5); wr(2'd2, 16'd5);
    #4;
    chk("R2", "reload written", reload_o, 5);
    chk("R2", "sel written", sel_o, 5);
    wr(2'd0, 16'd1);
    wait_slow(100);
    wr(2'd0, 16'd0);
    wait_ok();
    wait_slow(5);
    chk("R7", "flag set by wakeup", wake_flag_o, 1);
    wr(2'd3, 16'd0);
    #4 chk("R7", "write 0 keeps flag", wake_flag_o, 1);
    wr(2'd3, 16'd1);
    #4 chk("R7", "write 1 clears flag", wake_flag_o, 0);

    // enable then immediate disable: second write ignored
    wr(2'd0, 16'd1); wr(2'd0, 16'd0);
    #4 chk("R3", "disable in flight ignored", en_o, 1);
    wait_slow(4);
    wr(2'd0, 16'd0);
    wait_ok();
    chk("R3", "wr_ok after late disable", wr_ok_o, 1);
    wr(2'd3, 16'd1);

    // source 3 silent, others ticking: no movement
    tick_mask = 8'hF7;
    wr(2'd1, 16'd0); wr(2'd2, 16'd3); wr(2'd0, 16'd1);
    wait_slow(4);
    count_wake(40, c);
    chk("R8", "unselected ticks ignored", c, 0);
    chk("R8", "flag stays clear", wake_flag_o, 0);

    // source 3 ticking, reload 0: a pulse on every selected tick
    tick_mask = 8'hFF;
    wait_slow(4);
    count_wake(40, c);
    chk("R6", "reload 0 pulses every tick", c, 10);
    wr(2'd0, 16'd0);
    wait_ok();
    wait_slow(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule